// File: doc/BRIEF.md
# Debug Register Window Bridge

This bridge sits between a debug module's register request port and a processor's special-purpose register (SPR) bus. The debug side sees one 16-bit register address space with 32-bit data. The upper half of that space, where address bit 15 is set, is a window onto the SPR bus. Each access in the window becomes exactly one SPR read or write. The lower half holds local control registers. Only one of them exists: a page register that supplies the SPR address bits above bit 14.

The SPR address is the page register placed above the low 15 bits of the request address. A debugger therefore writes the page register once and can then reach 32K SPRs with one debug access each. For example, group 1 index 5 is SPR 0x0805. It is reached at debug address 0x8805 while the page is 0. The page width is a parameter, so cores with wider SPR spaces are handled by the same logic. The block also samples the core's debug stall line and emits a one-word event carrying the new stall value each time the line changes.

Top module: `dbg_spr_window`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `spr_stb` and `evt_valid` are 0, and the page register reads 0.
- R2: A request accepted with `req_addr[15]`=1 starts one SPR access in the next cycle. `spr_addr` is {page, `req_addr[14:0]`}, `spr_we` equals `req_write` and `spr_wdata` equals `req_wdata`. With page 0, address 0x8805 yields SPR 0x0805.
- R3: The page register sits at local address 0x0200. A write stores the low UPPER_W bits of `req_wdata`. A read returns the page zero-extended. Either access responds in the cycle after acceptance with `rsp_error`=0, and a write returns zero data. Neither access starts an SPR access.
- R4: The page value supplies SPR address bits 15 and up. With page 1, address 0x8805 yields SPR 0x8805.
- R5: `spr_stb` and `spr_addr` hold steady until a cycle with `spr_ack`=1. `spr_stb` is 0 in the following cycle, so each request produces one SPR transaction.
- R6: The window response is a one-cycle `rsp_valid` pulse in the cycle after the acknowledge, with `rsp_error`=0. Read data is the `spr_rdata` present on the acknowledge cycle. A write returns zero data.
- R7: A local address other than 0x0200 responds in the cycle after acceptance with `rsp_error`=1 and zero data. It starts no SPR access and leaves the page unchanged.
- R8: `req_ready` is 0 while an SPR access is in flight. A request held valid during that time is not accepted until `req_ready` returns to 1.
- R9: When the sampled `core_stall` differs from its previous sample (taken as 0 at reset), `evt_valid` pulses for one cycle on the next cycle with `evt_stall` equal to the new value. This happens regardless of request traffic. A steady stall line gives no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Debug request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Debug register address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_error | output | 1 | Unmapped local address |
| rsp_rdata | output | DW | Response read data |
| spr_stb | output | 1 | SPR access strobe |
| spr_we | output | 1 | SPR write enable |
| spr_addr | output | 15+UPPER_W | SPR address |
| spr_wdata | output | DW | SPR write data |
| spr_ack | input | 1 | SPR access complete |
| spr_rdata | input | DW | SPR read data |
| core_stall | input | 1 | Core debug stall line |
| evt_valid | output | 1 | Stall event pulse |
| evt_stall | output | 1 | Stall value carried by the event |

## Verification
The bench targets four cases:
- Translation at both page values. A design that drops or misplaces the page bits sends 0x8805 to SPR 0x0805 regardless of the page.
- Requests held valid against back-pressure, with acknowledge latencies of zero to several cycles. A bridge that accepts while busy, or that keeps the strobe up after the acknowledge, issues extra SPR transactions, and the cycle-level model flags them.
- Page writes whose data has upper bits set, and unmapped local addresses. These expose a page that latches too many bits, and a bad access that corrupts the page or reaches the SPR bus.
- Stall edges that arrive during a window access. These catch an event path that is gated by request traffic or that fires on a level rather than a change.

// File: rtl/dbg_spr_window.sv
module dbg_spr_window #(
  parameter int UPPER_W = 1,
  parameter int DW = 32,
  parameter logic [15:0] PAGE_ADDR = 16'h0200,
  localparam int SPR_AW = 15 + UPPER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [15:0]       req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DW-1:0]     rsp_rdata,
  output logic              spr_stb,
  output logic              spr_we,
  output logic [SPR_AW-1:0] spr_addr,
  output logic [DW-1:0]     spr_wdata,
  input  logic              spr_ack,
  input  logic [DW-1:0]     spr_rdata,
  input  logic              core_stall,
  output logic              evt_valid,
  output logic              evt_stall
);

  logic               busy;
  logic [UPPER_W-1:0] page_q;
  logic               stall_q;

  wire accept   = req_valid && !busy;
  wire in_win   = req_addr[15];
  wire page_hit = (req_addr == PAGE_ADDR);

  assign req_ready = !busy;
  assign spr_stb   = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      spr_we    <= 1'b0;
      spr_addr  <= '0;
      spr_wdata <= '0;
      page_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
      stall_q   <= 1'b0;
      evt_valid <= 1'b0;
      evt_stall <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      if (busy && spr_ack) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= spr_we ? '0 : spr_rdata;
      end else if (accept) begin
        if (in_win) begin
          busy      <= 1'b1;
          spr_we    <= req_write;
          spr_addr  <= {page_q, req_addr[14:0]};
          spr_wdata <= req_wdata;
        end else begin
          rsp_valid <= 1'b1;
          rsp_error <= !page_hit;
          rsp_rdata <= (page_hit && !req_write) ? {{(DW-UPPER_W){1'b0}}, page_q} : '0;
          if (page_hit && req_write) page_q <= req_wdata[UPPER_W-1:0];
        end
      end
      stall_q   <= core_stall;
      evt_valid <= core_stall != stall_q;
      evt_stall <= core_stall;
    end
  end

  // R5
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spr_stb && !spr_ack |=> spr_stb && $stable(spr_addr));

  // R5
  one_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spr_stb && spr_ack |=> !spr_stb);

  // R6
  rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spr_stb && spr_ack |=> rsp_valid && !rsp_error);

  // R8
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spr_stb |-> !req_ready);

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_error |-> rsp_rdata == '0);

endmodule

// File: tb/dbg_spr_window_tb.sv
module dbg_spr_window_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_error;
  logic [31:0] rsp_rdata;
  logic spr_stb, spr_we;
  logic [15:0] spr_addr;
  logic [31:0] spr_wdata;
  logic spr_ack = 0;
  logic [31:0] spr_rdata = 0;
  logic core_stall = 0;
  logic evt_valid, evt_stall;

  int checks = 0, fails = 0, lat = 0, wcnt = 0, cycles = 0;

  always #10 clk = ~clk;

  dbg_spr_window dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .spr_stb(spr_stb), .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
    .spr_ack(spr_ack), .spr_rdata(spr_rdata), .core_stall(core_stall),
    .evt_valid(evt_valid), .evt_stall(evt_stall));

  task automatic cmp(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", r, what, act, exp, $time);
    end
  endtask

  // reference model
  bit m_busy, m_we, m_rv, m_re, m_sq, m_ev, m_es;
  int unsigned m_addr, m_wd, m_rd, m_upper;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_upper = 0; m_rv = 0; m_re = 0; m_sq = 0; m_ev = 0; m_es = 0;
    end else begin
      m_rv = 0; m_re = 0;
      m_ev = (core_stall != m_sq); m_es = core_stall; m_sq = core_stall;
      if (m_busy) begin
        if (spr_ack) begin m_busy = 0; m_rv = 1; m_rd = m_we ? 0 : spr_rdata; end
      end else if (req_valid) begin
        if (req_addr >= 16'h8000) begin
          m_busy = 1; m_we = req_write; m_wd = req_wdata;
          m_addr = ((m_upper << 15) | (req_addr - 16'h8000)) & 16'hFFFF;
        end else if (req_addr == 16'h0200) begin
          m_rv = 1; m_rd = req_write ? 0 : m_upper;
          if (req_write) m_upper = req_wdata & 1;
        end else begin
          m_rv = 1; m_re = 1; m_rd = 0;
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n) begin
    cmp("R8", "req_ready", req_ready, !m_busy);
    cmp("R5", "spr_stb", spr_stb, m_busy);
    if (m_busy) begin
      cmp("R2", "spr_addr", spr_addr, m_addr);
      cmp("R2", "spr_we", spr_we, m_we);
      cmp("R2", "spr_wdata", spr_wdata, m_wd);
    end
    cmp("R6", "rsp_valid", rsp_valid, m_rv);
    if (m_rv) begin
      cmp("R7", "rsp_error", rsp_error, m_re);
      cmp("R6", "rsp_rdata", rsp_rdata, m_rd);
    end
    cmp("R9", "evt_valid", evt_valid, m_ev);
    if (m_ev) cmp("R9", "evt_stall", evt_stall, m_es);
  end

  // SPR responder
  always @(negedge clk) begin
    if (spr_ack) begin spr_ack = 0; wcnt = 0; end
    else if (spr_stb) begin
      if (wcnt >= lat) begin spr_ack = 1; spr_rdata = 32'hC0DE0000 ^ {16'h0, spr_addr}; end
      else wcnt++;
    end
  end

  task automatic req(bit w, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_rsp();
    int n = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    cmp("R1", "req_ready", req_ready, 1);
    cmp("R1", "rsp_valid", rsp_valid, 0);
    cmp("R1", "spr_stb", spr_stb, 0);
    cmp("R1", "evt_valid", evt_valid, 0);
    rst_n = 1;
    req(0, 16'h0200, 0);
    cmp("R1", "page after reset", rsp_rdata, 0);

    // R2 window read, page 0
    lat = 2;
    req(0, 16'h8805, 0);
    cmp("R2", "spr_addr 0x8805 page0", spr_addr, 16'h0805);
    cmp("R2", "spr_stb", spr_stb, 1);
    wait_rsp();
    cmp("R6", "read data", rsp_rdata, 32'hC0DE0805);

    // R3 page write masks to UPPER_W bits
    req(1, 16'h0200, 32'hFFFF_FFFF);
    cmp("R3", "page write rsp", rsp_valid, 1);
    cmp("R3", "page write data", rsp_rdata, 0);
    req(0, 16'h0200, 0);
    cmp("R3", "page readback", rsp_rdata, 1);
    cmp("R3", "no spr access", spr_stb, 0);

    // R4 page extends address
    lat = 0;
    req(1, 16'h8805, 32'h1234_5678);
    cmp("R4", "spr_addr page1", spr_addr, 16'h8805);
    cmp("R2", "spr_we", spr_we, 1);
    wait_rsp();
    cmp("R6", "write rsp data", rsp_rdata, 0);

    // R7 unmapped local
    req(1, 16'h0004, 32'h0);
    cmp("R7", "error", rsp_error, 1);
    cmp("R7", "no spr", spr_stb, 0);
    req(0, 16'h0200, 0);
    cmp("R7", "page unchanged", rsp_rdata, 1);

    // R8 back-to-back with held valid, R9 stall toggles during traffic
    lat = 4;
    fork
      begin
        req(0, 16'hFFFF, 0);
        req(0, 16'h8000, 0);
        req(0, 16'h0200, 0);
      end
      begin
        repeat (3) @(negedge clk);
        core_stall = 1;
        @(negedge clk);
        cmp("R9", "evt on rise", evt_valid, 1);
        cmp("R9", "evt value", evt_stall, 1);
        @(negedge clk);
        cmp("R9", "no evt steady", evt_valid, 0);
        repeat (2) @(negedge clk);
        core_stall = 0;
      end
    join
    @(negedge clk);
    req(1, 16'h0200, 0);
    lat = 1;
    for (int i = 0; i < 6; i++) begin
      req(i[0], 16'h8000 + 16'(i * 16'h0123), 32'hA000_0000 + i);
      core_stall = ~core_stall;
    end
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule